// File: doc/BRIEF.md
# Single-Bus Microcoded Processor Datapath

This block is the 32-bit datapath of a small multi-cycle processor for the RISC-V base integer instructions. Every transfer between its storage elements crosses one shared 32-bit bus. Each cycle, a control word from an external microcode sequencer picks at most one bus source: the immediate generator, the register RAM, the ALU or memory read data. The same word picks any number of sinks: the instruction register, operand latches A and B, the memory address register, and a register-RAM write.

The program counter is not a separate register. It sits in the register RAM at one extra index beyond the 32 general registers, so it is read and written like any other entry. The block gives the sequencer the current opcode and funct3, a condition flag taken from the ALU result, and a busy flag for memory accesses. Each instruction is run as a sequence of bus transfers. Examples are fetch, register and immediate arithmetic, load word, jump-and-link and conditional branch.

A memory access starts whenever the address register is loaded. The block pulses a request in the next cycle and reports busy until the memory releases its own busy line.

Top module: `sbus_datapath`

## Requirements
- R1: After reset the program counter entry holds RESET_PC (default 0), all general registers read 0, the instruction register is 0 (opcode output 0, base_len_ok 0), and mem_req is low.
- R2: bus_o carries the value of the single enabled source among imm_en, reg_en, alu_en and mem_en. It is 0 when none is enabled.
- R3: reg_sel selects the register-RAM entry for both read and write: 0 = rd (IR[11:7]), 1 = rs1 (IR[19:15]), 2 = rs2 (IR[24:20]), 3 = program counter. Entry x0 always reads 0, and writes to it are discarded.
- R4: imm_sel selects the immediate: 0 = I-type, sign-extended IR[31:20]. 1 = J-type, {IR[31] sign, IR[19:12], IR[20], IR[30:21], 0}. 2 = B-type, {IR[31] sign, IR[7], IR[30:25], IR[11:8], 0}. 3 = zero.
- R5: alu_op codes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 signed less-than, 6 unsigned less-than, 7 shift left, 8 logical shift right, 9 arithmetic shift right, 10 pass A, 11 A+4, 12 A-4, 13 equal, 14 not equal, 15 signed greater-or-equal. Shifts use B[4:0], and compares give 0 or 1. The cond output is high when the ALU result is nonzero.
- R6: ma_ld loads the address register (mem_addr) from the bus. mem_req is high for exactly the next cycle. busy equals mem_req OR mem_busy.
- R7: The fetch sequence loads the instruction word into IR (opcode = IR[6:0]) and advances the program counter by 4.
- R8: The register-register sequence writes ALUOp(rs1, rs2) to rd. The immediate sequence writes ALUOp(rs1, I-immediate) to rd.
- R9: The load-word sequence writes the word at rs1 + I-immediate into rd.
- R10: The jump-and-link sequence writes the incremented PC to rd and sets the PC to the instruction's address plus the J-immediate.
- R11: The branch sequence leaves the PC at the next instruction when the ALU compare is false. When it is true, the PC becomes the instruction's address plus the B-immediate.
- R12: base_len_ok is high exactly when IR[1:0] is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_en | input | 1 | Drive immediate onto bus |
| reg_en | input | 1 | Drive selected register-RAM entry onto bus |
| alu_en | input | 1 | Drive ALU result onto bus |
| mem_en | input | 1 | Drive memory read data onto bus |
| ir_ld | input | 1 | Load instruction register from bus |
| a_ld | input | 1 | Load operand latch A from bus |
| b_ld | input | 1 | Load operand latch B from bus |
| ma_ld | input | 1 | Load memory address register from bus, start access |
| reg_wr | input | 1 | Write bus into selected register-RAM entry |
| reg_sel | input | 2 | Register-RAM entry select |
| imm_sel | input | 2 | Immediate format select |
| alu_op | input | 4 | ALU operation |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory still working |
| mem_addr | output | 32 | Memory address register |
| mem_req | output | 1 | One-cycle access request |
| bus_o | output | 32 | Shared bus value |
| opcode | output | 7 | IR[6:0] |
| funct3 | output | 3 | IR[14:12] |
| cond | output | 1 | ALU result nonzero |
| busy | output | 1 | Access in progress |
| base_len_ok | output | 1 | IR holds a 32-bit base-length encoding |

## Verification
Single transfers come first. The bench reads each immediate format from two instruction words of opposite sign, which tells field scrambling apart from sign-extension faults. It runs all sixteen ALU codes on one negative and one positive operand, which separates signed from unsigned compares and arithmetic from logical shifts. Whole instruction sequences follow. They use a memory with non-zero latency, so a busy line dropped too early shows up as a wrong word. The branch is run not taken, taken forward and taken backward, so the PC-4 recovery and the negative B-immediate are each checked on their own.

// File: rtl/sbus_datapath.sv
`timescale 1ns/1ps
module sbus_datapath #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imm_en,
  input  logic            reg_en,
  input  logic            alu_en,
  input  logic            mem_en,
  input  logic            ir_ld,
  input  logic            a_ld,
  input  logic            b_ld,
  input  logic            ma_ld,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [1:0]      imm_sel,
  input  logic [3:0]      alu_op,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_busy,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_req,
  output logic [XLEN-1:0] bus_o,
  output logic [6:0]      opcode,
  output logic [2:0]      funct3,
  output logic            cond,
  output logic            busy,
  output logic            base_len_ok
);
  localparam int RIDX_W = $clog2(NREG + 1);
  localparam int PC_IDX = NREG;
  localparam int SHW    = $clog2(XLEN);

  logic [31:0]       ir_q;
  logic [XLEN-1:0]   a_q, b_q, ma_q;
  logic              req_q;
  logic [XLEN-1:0]   rf [0:NREG];
  logic [RIDX_W-1:0] ridx;
  logic [XLEN-1:0]   rf_rd, imm_v, alu_y;
  logic [SHW-1:0]    sh;
  logic              lt_s;

  always_comb begin
    case (reg_sel)
      2'd0:    ridx = RIDX_W'(ir_q[11:7]);
      2'd1:    ridx = RIDX_W'(ir_q[19:15]);
      2'd2:    ridx = RIDX_W'(ir_q[24:20]);
      default: ridx = RIDX_W'(PC_IDX);
    endcase
  end

  assign rf_rd = (ridx == '0) ? '0 : rf[ridx];

  always_comb begin
    case (imm_sel)
      2'd0:    imm_v = XLEN'({{20{ir_q[31]}}, ir_q[31:20]});
      2'd1:    imm_v = XLEN'({{12{ir_q[31]}}, ir_q[19:12], ir_q[20], ir_q[30:21], 1'b0});
      2'd2:    imm_v = XLEN'({{20{ir_q[31]}}, ir_q[7], ir_q[30:25], ir_q[11:8], 1'b0});
      default: imm_v = '0;
    endcase
  end

  assign sh   = b_q[SHW-1:0];
  assign lt_s = $signed(a_q) < $signed(b_q);

  always_comb begin
    case (alu_op)
      4'd0:    alu_y = a_q + b_q;
      4'd1:    alu_y = a_q - b_q;
      4'd2:    alu_y = a_q & b_q;
      4'd3:    alu_y = a_q | b_q;
      4'd4:    alu_y = a_q ^ b_q;
      4'd5:    alu_y = XLEN'(lt_s);
      4'd6:    alu_y = XLEN'(a_q < b_q);
      4'd7:    alu_y = a_q << sh;
      4'd8:    alu_y = a_q >> sh;
      4'd9:    alu_y = XLEN'($signed(a_q) >>> sh);
      4'd10:   alu_y = a_q;
      4'd11:   alu_y = a_q + XLEN'(4);
      4'd12:   alu_y = a_q - XLEN'(4);
      4'd13:   alu_y = XLEN'(a_q == b_q);
      4'd14:   alu_y = XLEN'(a_q != b_q);
      default: alu_y = XLEN'(!lt_s);
    endcase
  end

  assign bus_o = ({XLEN{imm_en}} & imm_v) | ({XLEN{reg_en}} & rf_rd)
               | ({XLEN{alu_en}} & alu_y) | ({XLEN{mem_en}} & mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      ma_q  <= '0;
      req_q <= 1'b0;
    end else begin
      if (ir_ld) ir_q <= bus_o[31:0];
      if (a_ld)  a_q  <= bus_o;
      if (b_ld)  b_q  <= bus_o;
      if (ma_ld) ma_q <= bus_o;
      req_q <= ma_ld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NREG; i++)
        rf[i] <= (i == PC_IDX) ? XLEN'(RESET_PC) : '0;
    end else if (reg_wr && ridx != '0) begin
      rf[ridx] <= bus_o;
    end
  end

  assign mem_addr    = ma_q;
  assign mem_req     = req_q;
  assign busy        = req_q | mem_busy;
  assign cond        = |alu_y;
  assign opcode      = ir_q[6:0];
  assign funct3      = ir_q[14:12];
  assign base_len_ok = &ir_q[1:0];
endmodule

// File: rtl/sbus_datapath_chk.sv
`timescale 1ns/1ps
module sbus_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imm_en,
  input logic            reg_en,
  input logic            alu_en,
  input logic            mem_en,
  input logic            ir_ld,
  input logic            ma_ld,
  input logic [1:0]      reg_sel,
  input logic [XLEN-1:0] bus_o,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_req,
  input logic            busy,
  input logic [6:0]      opcode,
  input logic            cond,
  input logic [31:0]     ir_q
);
  assert_single_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imm_en, reg_en, alu_en, mem_en}));

  assert_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_en | reg_en | alu_en | mem_en) |-> bus_o == '0);

  assert_x0_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_sel == 2'd1 && ir_q[19:15] == 5'd0) |-> bus_o == '0);

  assert_cond_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |-> cond == (bus_o != '0));

  assert_addr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ma_ld |=> (mem_req && mem_addr == $past(bus_o)));

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !ma_ld) |=> !mem_req);

  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_ir_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> opcode == $past(bus_o[6:0]));
endmodule

bind sbus_datapath sbus_datapath_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .imm_en(imm_en), .reg_en(reg_en), .alu_en(alu_en),
  .mem_en(mem_en), .ir_ld(ir_ld), .ma_ld(ma_ld), .reg_sel(reg_sel), .bus_o(bus_o),
  .mem_addr(mem_addr), .mem_req(mem_req), .busy(busy), .opcode(opcode),
  .cond(cond), .ir_q(ir_q)
);

// File: tb/sbus_datapath_test.sv
`timescale 1ns/1ps
module sbus_datapath_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imm_en, reg_en, alu_en, mem_en, ir_ld, a_ld, b_ld, ma_ld, reg_wr;
  logic [1:0] reg_sel, imm_sel;
  logic [3:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, bus_o;
  logic mem_busy, mem_req, cond, busy, base_len_ok;
  logic [6:0] opcode;
  logic [2:0] funct3;

  logic [31:0] mem [0:63];
  logic frc = 1'b0;
  logic [31:0] fval = '0;
  int lat = 0;
  int cnt = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  sbus_datapath uut (
    .clk(clk), .rst_n(rst_n), .imm_en(imm_en), .reg_en(reg_en), .alu_en(alu_en),
    .mem_en(mem_en), .ir_ld(ir_ld), .a_ld(a_ld), .b_ld(b_ld), .ma_ld(ma_ld),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .imm_sel(imm_sel), .alu_op(alu_op),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy), .mem_addr(mem_addr), .mem_req(mem_req),
    .bus_o(bus_o), .opcode(opcode), .funct3(funct3), .cond(cond), .busy(busy),
    .base_len_ok(base_len_ok)
  );

  assign mem_rdata = frc ? fval : mem[mem_addr[7:2]];
  assign mem_busy  = (cnt != 0);
  always @(posedge clk) begin
    if (mem_req) cnt <= lat;
    else if (cnt != 0) cnt <= cnt - 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    {imm_en, reg_en, alu_en, mem_en, ir_ld, a_ld, b_ld, ma_ld, reg_wr} = '0;
    reg_sel = 2'd0; imm_sel = 2'd0; alu_op = 4'd0; frc = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_ir(input logic [31:0] w);
    clr(); frc = 1'b1; fval = w; mem_en = 1'b1; ir_ld = 1'b1; tick(); clr();
  endtask

  task automatic poke(input int n, input logic [31:0] v);
    load_ir((32'(n) << 7) | 32'h13);
    frc = 1'b1; fval = v; mem_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; tick(); clr();
  endtask

  task automatic peek(input int n, output logic [31:0] v);
    load_ir((32'(n) << 15) | 32'h13);
    reg_en = 1'b1; reg_sel = 2'd1; #1 v = bus_o; clr();
  endtask

  task automatic peek_pc(output logic [31:0] v);
    clr(); reg_en = 1'b1; reg_sel = 2'd3; #1 v = bus_o; clr();
  endtask

  task automatic wait_mem();
    clr(); #1;
    for (int n = 0; busy && n < 100; n++) begin tick(); #1; end
  endtask

  task automatic fetch(input logic [31:0] instr);
    logic [31:0] v;
    mem[exp_pc[7:2]] = instr;
    clr(); reg_en = 1'b1; reg_sel = 2'd3; ma_ld = 1'b1; a_ld = 1'b1; tick();
    wait_mem();
    clr(); mem_en = 1'b1; ir_ld = 1'b1; tick();
    clr(); alu_en = 1'b1; alu_op = 4'd11; reg_wr = 1'b1; reg_sel = 2'd3; tick(); clr();
    exp_pc = exp_pc + 4;
    #1 chk("R7 opcode after fetch", {25'b0, opcode}, {25'b0, instr[6:0]});
    peek_pc(v);
    chk("R7 pc after fetch", v, exp_pc);
  endtask

  task automatic op_a_rs1_b(input logic use_imm);
    clr(); reg_en = 1'b1; reg_sel = 2'd1; a_ld = 1'b1; tick();
    clr();
    if (use_imm) begin imm_en = 1'b1; imm_sel = 2'd0; end
    else begin reg_en = 1'b1; reg_sel = 2'd2; end
    b_ld = 1'b1; tick(); clr();
  endtask

  function automatic logic [31:0] imm_i(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction
  function automatic logic [31:0] imm_j(input logic [31:0] w);
    return {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
  endfunction
  function automatic logic [31:0] imm_b(input logic [31:0] w);
    return {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk("R1 mem_req low", {31'b0, mem_req}, 32'd0);
    chk("R1 busy low", {31'b0, busy}, 32'd0);
    chk("R1 opcode zero", {25'b0, opcode}, 32'd0);
    chk("R1 base_len_ok low", {31'b0, base_len_ok}, 32'd0);
    chk("R2 idle bus zero", bus_o, 32'd0);
    peek_pc(v); chk("R1 pc reset", v, 32'h0);
    peek(5, v); chk("R1 x5 reset", v, 32'd0);
    peek(31, v); chk("R1 x31 reset", v, 32'd0);
  endtask

  task automatic t_imm();
    logic [31:0] words [2];
    words[0] = 32'h8A5C3F97; words[1] = 32'h71356A53;
    foreach (words[k]) begin
      load_ir(words[k]);
      imm_en = 1'b1;
      imm_sel = 2'd0; #1 chk("R4 I immediate", bus_o, imm_i(words[k])); tick();
      imm_sel = 2'd1; #1 chk("R4 J immediate", bus_o, imm_j(words[k])); tick();
      imm_sel = 2'd2; #1 chk("R4 B immediate", bus_o, imm_b(words[k])); tick();
      imm_sel = 2'd3; #1 chk("R4 zero immediate", bus_o, 32'd0); tick();
      clr();
    end
  endtask

  task automatic t_regsel();
    logic [31:0] v;
    poke(7, 32'h00001234);
    poke(0, 32'hDEADBEEF);
    peek(0, v); chk("R3 x0 write discarded", v, 32'd0);
    peek(7, v); chk("R3 rs1 select", v, 32'h00001234);
    load_ir((32'd7 << 20) | 32'h33);
    reg_en = 1'b1; reg_sel = 2'd2; #1 chk("R3 rs2 select", bus_o, 32'h00001234); tick();
    load_ir((32'd7 << 7) | 32'h33);
    reg_en = 1'b1; reg_sel = 2'd0; #1 chk("R3 rd select", bus_o, 32'h00001234); tick(); clr();
  endtask

  task automatic t_alu();
    logic [31:0] expv [16];
    expv = '{32'hFFFFFFF3, 32'hFFFFFFED, 32'h00000000, 32'hFFFFFFF3,
             32'hFFFFFFF3, 32'h00000001, 32'h00000000, 32'hFFFFFF80,
             32'h1FFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFF0, 32'hFFFFFFF4,
             32'hFFFFFFEC, 32'h00000000, 32'h00000001, 32'h00000000};
    clr(); frc = 1'b1; fval = 32'hFFFFFFF0; mem_en = 1'b1; a_ld = 1'b1; tick();
    fval = 32'd3; a_ld = 1'b0; b_ld = 1'b1; tick(); clr();
    for (int op = 0; op < 16; op++) begin
      alu_en = 1'b1; alu_op = 4'(op); #1;
      chk($sformatf("R5 alu op %0d", op), bus_o, expv[op]);
      chk($sformatf("R5 cond op %0d", op), {31'b0, cond}, {31'b0, expv[op] != 0});
      tick();
    end
    clr();
  endtask

  task automatic t_mem();
    int n;
    lat = 3;
    clr(); frc = 1'b1; fval = 32'h00000040; mem_en = 1'b1; ma_ld = 1'b1; tick(); clr();
    #1;
    chk("R6 mem_addr loaded", mem_addr, 32'h40);
    chk("R6 mem_req pulse", {31'b0, mem_req}, 32'd1);
    n = 0;
    while (busy && n < 50) begin n++; tick(); #1;
      if (n == 1) chk("R6 mem_req one cycle", {31'b0, mem_req}, 32'd0);
    end
    chk("R6 busy cycles", 32'(n), 32'd4);
  endtask

  task automatic t_arith();
    logic [31:0] v;
    lat = 2;
    poke(1, 32'd100); poke(2, 32'hFFFFFFE2);
    fetch(32'h002081B3);
    op_a_rs1_b(1'b0);
    alu_en = 1'b1; alu_op = 4'd1; reg_wr = 1'b1; reg_sel = 2'd0; tick(); clr();
    peek(3, v); chk("R8 reg-reg sub result", v, 32'd130);
    fetch(32'hFFB08213);
    op_a_rs1_b(1'b1);
    alu_en = 1'b1; alu_op = 4'd0; reg_wr = 1'b1; reg_sel = 2'd0; tick(); clr();
    peek(4, v); chk("R8 immediate add result", v, 32'd95);
  endtask

  task automatic t_load();
    logic [31:0] v;
    poke(1, 32'h00000080);
    mem[34] = 32'hCAFEF00D;
    fetch(32'h0080A283);
    op_a_rs1_b(1'b1);
    alu_en = 1'b1; alu_op = 4'd0; ma_ld = 1'b1; tick();
    wait_mem();
    clr(); mem_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; tick(); clr();
    peek(5, v); chk("R9 load word result", v, 32'hCAFEF00D);
  endtask

  task automatic t_jal();
    logic [31:0] v, p;
    p = exp_pc;
    fetch(32'h010000EF);
    clr(); reg_en = 1'b1; reg_sel = 2'd3; a_ld = 1'b1; tick();
    clr(); alu_en = 1'b1; alu_op = 4'd10; reg_wr = 1'b1; reg_sel = 2'd0; tick();
    clr(); alu_en = 1'b1; alu_op = 4'd12; a_ld = 1'b1; tick();
    clr(); imm_en = 1'b1; imm_sel = 2'd1; b_ld = 1'b1; tick();
    clr(); alu_en = 1'b1; alu_op = 4'd0; reg_wr = 1'b1; reg_sel = 2'd3; tick(); clr();
    exp_pc = p + 16;
    peek_pc(v); chk("R10 jal target", v, exp_pc);
    peek(1, v); chk("R10 jal link", v, p + 4);
  endtask

  task automatic t_branch(input logic [31:0] w, input logic exp_take, input string tag);
    logic [31:0] v, p;
    logic c;
    p = exp_pc;
    fetch(w);
    op_a_rs1_b(1'b0);
    alu_op = 4'd13; #1 c = cond; tick(); clr();
    chk({"R11 cond ", tag}, {31'b0, c}, {31'b0, exp_take});
    if (c) begin
      clr(); reg_en = 1'b1; reg_sel = 2'd3; a_ld = 1'b1; tick();
      clr(); alu_en = 1'b1; alu_op = 4'd12; a_ld = 1'b1; tick();
      clr(); imm_en = 1'b1; imm_sel = 2'd2; b_ld = 1'b1; tick();
      clr(); alu_en = 1'b1; alu_op = 4'd0; reg_wr = 1'b1; reg_sel = 2'd3; tick(); clr();
    end
    exp_pc = exp_take ? p + imm_b(w) : p + 4;
    peek_pc(v); chk({"R11 pc ", tag}, v, exp_pc);
  endtask

  task automatic t_len();
    load_ir(32'h00000011); #1 chk("R12 short encoding flagged", {31'b0, base_len_ok}, 32'd0);
    load_ir(32'h00000013); #1 chk("R12 base encoding", {31'b0, base_len_ok}, 32'd1);
    chk("R7 funct3 output", {29'b0, funct3}, 32'd0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    clr();
    exp_pc = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_imm();
    t_regsel();
    t_alu();
    t_mem();
    t_arith();
    t_load();
    t_jal();
    poke(2, 32'hFFFFFFE2); poke(3, 32'd130);
    t_branch(32'h00310463, 1'b0, "not taken");
    poke(3, 32'hFFFFFFE2);
    t_branch(32'h00310463, 1'b1, "taken forward");
    t_branch(32'hFE310CE3, 1'b1, "taken backward");
    t_len();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end
endmodule